// File: doc/BRIEF.md
# Configurable Look-Up Table Slice

This block models one logic slice built around two 16-entry look-up tables, named F and G. Each table holds one 16-bit store that is addressed by four inputs. Depending on a slice mode word, the store serves as a combinational function generator, as a RAM with a synchronous write, or as a shift register with an addressable tap. The two tables can also be joined. Joined, they form a 16x2 RAM, a 32x1 RAM, a 16x1 RAM with separate write and read ports, or one function of five inputs.

Each table output goes straight to a combinational slice output. The same signal also feeds a storage element. A per-element bypass select can replace that data with a direct slice input. Each storage element is set up as an edge-triggered flip-flop or as a latch that is open while the clock is high. Both kinds share a clock enable and a synchronous clear line.

A configuration load writes both table images and all mode bits on one clock edge. The slice is used by loading a configuration once and then driving the address, write and bypass inputs.

Top module: `lut_slice_cell`

## Requirements
- R1: In mode 0 (function), comb_f equals bit a_f of the F image and comb_g equals bit a_g of the G image. A rising clock edge with we high leaves both tables unchanged.
- R2: In mode 1 (two single RAMs), a rising clock edge with we high writes wd_f to F[a_f] and wd_g to G[a_g]. The outputs comb_f and comb_g read F[a_f] and G[a_g] without waiting for a clock.
- R3: In mode 2 (16x2 RAM), a write stores wd_f to F[a_f] and wd_g to G[a_f]. The output comb_g reads G[a_f] and ignores a_g.
- R4: In mode 3 (32x1 RAM), the address is {x5, a_f}. A write goes to F when x5 is 0 and to G when x5 is 1, with data wd_f. The output comb_f reads the table that x5 selects.
- R5: In mode 4 (dual port), a write stores wd_f at address a_f in both tables. The output comb_f reads F[a_f] and comb_g reads G at the independent address a_g.
- R6: In mode 5 (shift), each rising edge with we high moves every bit of F up one place and loads wd_f into bit 0 (G does the same with wd_g). comb_f and comb_g read the bits at a_f and a_g, and casc_f and casc_g show bit 15.
- R7: In mode 6 (five-input function), comb_f equals G[a_f] when x5 is 1 and F[a_f] when x5 is 0. We has no effect on the tables.
- R8: With a storage element in flip-flop mode (latch bit 0), a rising edge with ce high loads its D. When ce is low the element holds. With bypass off, D is the table's combinational output.
- R9: With a storage element in latch mode (latch bit 1), the output follows D while clk and ce are both high. It holds while clk is low or ce is low.
- R10: Bypass bit 1 makes an element's D the direct input (byp_f or byp_g) instead of the table output. Bit 0 of cfg_latch and cfg_bypass controls the F element and bit 1 controls the G element.
- R11: srst high at a rising edge clears a flip-flop element whatever ce is. srst also clears a latch element while clk is high.
- R12: A rising edge with cfg_we high loads cfg_init_f, cfg_init_g, cfg_mode, cfg_latch and cfg_bypass. This load wins over a write or a shift on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| srst | input | 1 | Synchronous clear of the storage elements |
| ce | input | 1 | Clock enable for both storage elements |
| cfg_we | input | 1 | Load configuration on this edge |
| cfg_init_f | input | 16 | Image loaded into table F |
| cfg_init_g | input | 16 | Image loaded into table G |
| cfg_mode | input | 3 | Slice mode code 0..6 |
| cfg_latch | input | 2 | Per element: 1 = latch, 0 = flip-flop |
| cfg_bypass | input | 2 | Per element: 1 = direct input drives D |
| a_f | input | 4 | Table F address / function inputs |
| a_g | input | 4 | Table G address / function inputs |
| x5 | input | 1 | Fifth address / function input |
| we | input | 1 | Write or shift enable |
| wd_f | input | 1 | Write / shift data for F (shared data in modes 3, 4) |
| wd_g | input | 1 | Write / shift data for G |
| byp_f | input | 1 | Direct data for the F storage element |
| byp_g | input | 1 | Direct data for the G storage element |
| comb_f | output | 1 | Combinational output of the F side |
| comb_g | output | 1 | Combinational output of the G side |
| q_f | output | 1 | F storage element output |
| q_g | output | 1 | G storage element output |
| casc_f | output | 1 | Bit 15 of table F |
| casc_g | output | 1 | Bit 15 of table G |

## Verification
The bench builds the slice with its default four address inputs. Each table then has only 16 entries, so every address of every RAM mode can be written and read back. All 32 combinations of the joined 32x1 and five-input modes are swept. Shift sequences longer than the table push the loaded bits out through the cascade output. The bench also moves D during the high clock phase, and that is how the latch is told apart from the flip-flop.

// File: rtl/lut_slice_pkg.sv
`timescale 1ns/1ps
package lut_slice_pkg;

  typedef enum logic [2:0] {
    MODE_FUNC   = 3'd0,
    MODE_RAM1   = 3'd1,
    MODE_RAM2W  = 3'd2,
    MODE_RAM32  = 3'd3,
    MODE_DPORT  = 3'd4,
    MODE_SHIFT  = 3'd5,
    MODE_FUNC5  = 3'd6,
    MODE_RSVD   = 3'd7
  } slice_mode_e;

  typedef struct packed {
    logic use_latch;
    logic use_bypass;
  } store_cfg_t;

  // 2:1 selection used by the joined modes.
  function automatic logic pick_half(input logic hi_sel, input logic lo_bit, input logic hi_bit);
    return hi_sel ? hi_bit : lo_bit;
  endfunction

endpackage

// File: rtl/lut_table.sv
`timescale 1ns/1ps
module lut_table #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              load_en,
  input  logic [DEPTH-1:0]  load_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              sh_en,
  input  logic              sh_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  output logic              top_bit,
  output logic [DEPTH-1:0]  contents
);

  logic [DEPTH-1:0] store_q;

  function automatic logic [DEPTH-1:0] put_bit(input logic [DEPTH-1:0] t,
                                               input logic [ADDR_W-1:0] a,
                                               input logic b);
    logic [DEPTH-1:0] r;
    r    = t;
    r[a] = b;
    return r;
  endfunction

  function automatic logic [DEPTH-1:0] push_bit(input logic [DEPTH-1:0] t, input logic b);
    return {t[DEPTH-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (load_en)     store_q <= load_val;
    else if (sh_en)  store_q <= push_bit(store_q, sh_bit);
    else if (wr_en)  store_q <= put_bit(store_q, wr_addr, wr_bit);
  end

  assign rd_bit   = store_q[rd_addr];
  assign top_bit  = store_q[DEPTH-1];
  assign contents = store_q;

endmodule

// File: rtl/slice_storage.sv
`timescale 1ns/1ps
module slice_storage
  import lut_slice_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       ce,
  input  store_cfg_t cfg,
  input  logic       comb_in,
  input  logic       byp_in,
  output logic       q
);

  logic d_sel;
  logic q_ff;
  logic q_lat;
  logic lat_open;

  assign d_sel    = cfg.use_bypass ? byp_in : comb_in;
  assign lat_open = clk && (ce || srst);

  always_ff @(posedge clk) begin
    if (srst)    q_ff <= 1'b0;
    else if (ce) q_ff <= d_sel;
  end

  always_latch begin
    if (lat_open) q_lat = srst ? 1'b0 : d_sel;
  end

  assign q = cfg.use_latch ? q_lat : q_ff;

endmodule

// File: rtl/lut_slice_cell.sv
`timescale 1ns/1ps
module lut_slice_cell
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              ce,
  input  logic              cfg_we,
  input  logic [DEPTH-1:0]  cfg_init_f,
  input  logic [DEPTH-1:0]  cfg_init_g,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_latch,
  input  logic [1:0]        cfg_bypass,
  input  logic [ADDR_W-1:0] a_f,
  input  logic [ADDR_W-1:0] a_g,
  input  logic              x5,
  input  logic              we,
  input  logic              wd_f,
  input  logic              wd_g,
  input  logic              byp_f,
  input  logic              byp_g,
  output logic              comb_f,
  output logic              comb_g,
  output logic              q_f,
  output logic              q_g,
  output logic              casc_f,
  output logic              casc_g
);

  slice_mode_e mode_q;
  store_cfg_t  st_cfg_q [2];

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      mode_q      <= slice_mode_e'(cfg_mode);
      st_cfg_q[0] <= '{use_latch: cfg_latch[0], use_bypass: cfg_bypass[0]};
      st_cfg_q[1] <= '{use_latch: cfg_latch[1], use_bypass: cfg_bypass[1]};
    end
  end

  // Named internal events for the checker.
  logic              wr_f_evt, wr_g_evt, sh_f_evt, sh_g_evt;
  logic [ADDR_W-1:0] wa_f, wa_g, ra_f, ra_g;
  logic              wb_f, wb_g;
  logic              rb_f, rb_g;
  logic [DEPTH-1:0]  tab_f, tab_g;
  logic              act_we;

  assign act_we = we && !cfg_we;

  always_comb begin
    wr_f_evt = 1'b0;
    wr_g_evt = 1'b0;
    sh_f_evt = 1'b0;
    sh_g_evt = 1'b0;
    wa_f     = a_f;
    wa_g     = a_g;
    wb_f     = wd_f;
    wb_g     = wd_g;
    ra_f     = a_f;
    ra_g     = a_g;
    comb_f   = rb_f;
    comb_g   = rb_g;
    unique case (mode_q)
      MODE_RAM1: begin
        wr_f_evt = act_we;
        wr_g_evt = act_we;
      end
      MODE_RAM2W: begin
        wr_f_evt = act_we;
        wr_g_evt = act_we;
        wa_g     = a_f;
        ra_g     = a_f;
      end
      MODE_RAM32: begin
        wr_f_evt = act_we && !x5;
        wr_g_evt = act_we && x5;
        wa_g     = a_f;
        wb_g     = wd_f;
        ra_g     = a_f;
        comb_f   = pick_half(x5, rb_f, rb_g);
      end
      MODE_DPORT: begin
        wr_f_evt = act_we;
        wr_g_evt = act_we;
        wa_g     = a_f;
        wb_g     = wd_f;
      end
      MODE_SHIFT: begin
        sh_f_evt = act_we;
        sh_g_evt = act_we;
      end
      MODE_FUNC5: begin
        ra_g   = a_f;
        comb_f = pick_half(x5, rb_f, rb_g);
      end
      default: begin
      end
    endcase
  end

  lut_table #(.ADDR_W(ADDR_W)) tab_f_i (
    .clk(clk), .load_en(cfg_we), .load_val(cfg_init_f),
    .wr_en(wr_f_evt), .wr_addr(wa_f), .wr_bit(wb_f),
    .sh_en(sh_f_evt), .sh_bit(wd_f),
    .rd_addr(ra_f), .rd_bit(rb_f), .top_bit(casc_f), .contents(tab_f)
  );

  lut_table #(.ADDR_W(ADDR_W)) tab_g_i (
    .clk(clk), .load_en(cfg_we), .load_val(cfg_init_g),
    .wr_en(wr_g_evt), .wr_addr(wa_g), .wr_bit(wb_g),
    .sh_en(sh_g_evt), .sh_bit(wd_g),
    .rd_addr(ra_g), .rd_bit(rb_g), .top_bit(casc_g), .contents(tab_g)
  );

  slice_storage st_f_i (
    .clk(clk), .srst(srst), .ce(ce), .cfg(st_cfg_q[0]),
    .comb_in(comb_f), .byp_in(byp_f), .q(q_f)
  );

  slice_storage st_g_i (
    .clk(clk), .srst(srst), .ce(ce), .cfg(st_cfg_q[1]),
    .comb_in(comb_g), .byp_in(byp_g), .q(q_g)
  );

endmodule

// File: rtl/lut_slice_chk.sv
`timescale 1ns/1ps
module lut_slice_chk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              srst,
  input logic              ce,
  input logic              cfg_we,
  input logic [DEPTH-1:0]  cfg_init_f,
  input logic              we,
  input logic              wd_f,
  input logic [ADDR_W-1:0] a_f,
  input logic              comb_f,
  input logic              q_f,
  input logic              casc_f,
  input logic [2:0]        mode_v,
  input logic              latch_f,
  input logic [DEPTH-1:0]  tab_f,
  input logic [DEPTH-1:0]  tab_g
);

  // R1
  func_keeps_tables_chk: assert property (@(posedge clk) disable iff (srst)
    (mode_v == 3'd0 && !cfg_we) |=> ($stable(tab_f) && $stable(tab_g)));

  // R2
  ram_readback_chk: assert property (@(posedge clk) disable iff (srst)
    (mode_v == 3'd1 && we && !cfg_we) |=> ((a_f != $past(a_f)) || (comb_f == $past(wd_f))));

  // R6
  shift_cascade_chk: assert property (@(posedge clk) disable iff (srst)
    (mode_v == 3'd5 && we && !cfg_we) |=> (casc_f == $past(tab_f[DEPTH-2])));

  // R8
  ff_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!latch_f && !ce && !cfg_we) |=> $stable(q_f));

  // R12
  cfg_load_chk: assert property (@(posedge clk) disable iff (srst)
    cfg_we |=> (tab_f == $past(cfg_init_f)));

endmodule

bind lut_slice_cell lut_slice_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .srst(srst), .ce(ce), .cfg_we(cfg_we), .cfg_init_f(cfg_init_f),
  .we(we), .wd_f(wd_f), .a_f(a_f), .comb_f(comb_f), .q_f(q_f), .casc_f(casc_f),
  .mode_v(mode_q), .latch_f(st_cfg_q[0].use_latch), .tab_f(tab_f), .tab_g(tab_g)
);

// File: tb/lut_slice_cell_tb_top.sv
`timescale 1ns/1ps
module lut_slice_cell_tb_top;

  localparam int AW   = 4;
  localparam int N    = 1 << AW;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic srst, ce, cfg_we, x5, we, wd_f, wd_g, byp_f, byp_g;
  logic [N-1:0] cfg_init_f, cfg_init_g;
  logic [2:0] cfg_mode;
  logic [1:0] cfg_latch, cfg_bypass;
  logic [AW-1:0] a_f, a_g;
  logic comb_f, comb_g, q_f, q_g, casc_f, casc_g;

  int vectors = 0;
  int miscompares = 0;
  int mf, mg;

  always #(HALF) clk = ~clk;

  lut_slice_cell #(.ADDR_W(AW)) dut_i (
    .clk(clk), .srst(srst), .ce(ce), .cfg_we(cfg_we),
    .cfg_init_f(cfg_init_f), .cfg_init_g(cfg_init_g), .cfg_mode(cfg_mode),
    .cfg_latch(cfg_latch), .cfg_bypass(cfg_bypass),
    .a_f(a_f), .a_g(a_g), .x5(x5), .we(we), .wd_f(wd_f), .wd_g(wd_g),
    .byp_f(byp_f), .byp_g(byp_g),
    .comb_f(comb_f), .comb_g(comb_g), .q_f(q_f), .q_g(q_g),
    .casc_f(casc_f), .casc_g(casc_g)
  );

  function automatic int bit_of(int v, int i);
    return (v / (2 ** i)) % 2;
  endfunction

  function automatic int set_bit(int v, int i, int b);
    int cur;
    cur = bit_of(v, i);
    if (cur == b) return v;
    return b != 0 ? v + 2 ** i : v - 2 ** i;
  endfunction

  function automatic int shift_in(int v, int b);
    return (v * 2 + b) % (2 ** N);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic load(input int mode, input int lat, input int byp, input int fi, input int gi);
    cfg_we     = 1'b1;
    cfg_mode   = 3'(mode);
    cfg_latch  = 2'(lat);
    cfg_bypass = 2'(byp);
    cfg_init_f = N'(fi);
    cfg_init_g = N'(gi);
    tick();
    cfg_we = 1'b0;
    mf = fi;
    mg = gi;
  endtask

  initial begin
    #(2 * HALF * 200000);
    miscompares++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    srst = 1'b1; ce = 1'b1; cfg_we = 1'b0; x5 = 1'b0; we = 1'b0;
    wd_f = 1'b0; wd_g = 1'b0; byp_f = 1'b0; byp_g = 1'b0;
    a_f = '0; a_g = '0; cfg_mode = '0; cfg_latch = '0; cfg_bypass = '0;
    cfg_init_f = '0; cfg_init_g = '0;
    @(negedge clk); #1;
    load(0, 0, 0, 16'hA5C3, 16'h3C96);
    tick();
    chk("R11 reset q_f", q_f, 0);
    chk("R11 reset q_g", q_g, 0);
    srst = 1'b0;

    // R1: function mode sweep, then we has no effect
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(N - 1 - a); #1;
      chk("R1 comb_f", comb_f, bit_of(mf, a));
      chk("R1 comb_g", comb_g, bit_of(mg, N - 1 - a));
    end
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(a); we = 1'b1;
      wd_f = ~1'(bit_of(mf, a)); wd_g = ~1'(bit_of(mg, a));
      tick();
    end
    we = 1'b0;
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(a); #1;
      chk("R1 after we comb_f", comb_f, bit_of(mf, a));
      chk("R1 after we comb_g", comb_g, bit_of(mg, a));
    end

    // R8: flip-flop captures the table output; holds with ce low
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(N - 1 - a);
      tick();
      chk("R8 q_f from table", q_f, bit_of(mf, a));
      chk("R8 q_g from table", q_g, bit_of(mg, N - 1 - a));
    end
    a_f = 4'd0; tick();
    ce = 1'b0; a_f = 4'd1; tick();
    chk("R8 hold ce low", q_f, bit_of(mf, 0));
    ce = 1'b1;

    // R10: bypass drives D
    load(0, 0, 3, 16'hA5C3, 16'h3C96);
    byp_f = 1'b1; byp_g = 1'b0; tick();
    chk("R10 q_f bypass", q_f, 1);
    chk("R10 q_g bypass", q_g, 0);
    byp_f = 1'b0; byp_g = 1'b1; tick();
    chk("R10 q_f bypass flip", q_f, 0);
    chk("R10 q_g bypass flip", q_g, 1);

    // R11: flip-flop clear ignores ce
    ce = 1'b0; srst = 1'b1; tick();
    chk("R11 ff clear with ce low", q_g, 0);
    srst = 1'b0; ce = 1'b1;

    // R9: latch behaviour
    load(0, 3, 3, 16'hA5C3, 16'h3C96);
    byp_f = 1'b0; byp_g = 1'b1;
    @(posedge clk); #1;
    chk("R9 latch open value", q_f, 0);
    byp_f = 1'b1; #1;
    chk("R9 latch follows while high", q_f, 1);
    @(negedge clk); #1;
    byp_f = 1'b0; #1;
    chk("R9 latch holds while low", q_f, 1);
    ce = 1'b0;
    @(posedge clk); #1;
    byp_f = 1'b0; #1;
    chk("R9 latch closed by ce", q_f, 1);
    chk("R9 latch g closed by ce", q_g, 1);
    srst = 1'b1; #1;
    chk("R11 latch cleared while high", q_g, 0);
    @(negedge clk); #1;
    srst = 1'b0; ce = 1'b1;

    // R2: two single RAMs
    load(1, 0, 0, 0, 16'hFFFF);
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(N - 1 - a); we = 1'b1;
      wd_f = 1'((a * 5 + 1) % 3 == 0); wd_g = 1'(a % 2);
      mf = set_bit(mf, a, int'(wd_f)); mg = set_bit(mg, N - 1 - a, int'(wd_g));
      tick();
    end
    we = 1'b0;
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(a); #1;
      chk("R2 comb_f", comb_f, bit_of(mf, a));
      chk("R2 comb_g", comb_g, bit_of(mg, a));
    end

    // R3: 16x2 RAM, shared address
    load(2, 0, 0, 16'h00FF, 16'hF00F);
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'((a + 7) % N); we = 1'b1;
      wd_f = 1'(a % 3 == 0); wd_g = 1'(a % 4 != 1);
      mf = set_bit(mf, a, int'(wd_f)); mg = set_bit(mg, a, int'(wd_g));
      tick();
    end
    we = 1'b0;
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'((a + 3) % N); #1;
      chk("R3 comb_f", comb_f, bit_of(mf, a));
      chk("R3 comb_g at a_f", comb_g, bit_of(mg, a));
    end

    // R4: 32x1 RAM
    load(4'd3, 0, 0, 16'h1234, 16'hFEDC);
    for (int k = 0; k < 2 * N; k++) begin
      a_f = AW'(k % N); x5 = 1'(k / N); we = 1'b1;
      wd_f = 1'((k * 7 + 2) % 5 < 2); wd_g = ~wd_f;
      if (k < N) mf = set_bit(mf, k % N, int'(wd_f));
      else       mg = set_bit(mg, k % N, int'(wd_f));
      tick();
    end
    we = 1'b0;
    for (int k = 0; k < 2 * N; k++) begin
      a_f = AW'(k % N); x5 = 1'(k / N); #1;
      chk("R4 comb_f", comb_f, k < N ? bit_of(mf, k) : bit_of(mg, k - N));
    end
    x5 = 1'b0;

    // R5: dual port
    load(4, 0, 0, 16'h0000, 16'hFFFF);
    for (int a = 0; a < N; a++) begin
      a_f = AW'(a); a_g = AW'(N - 1 - a); we = 1'b1;
      wd_f = 1'(a % 3 != 2); wd_g = ~wd_f;
      mf = set_bit(mf, a, int'(wd_f)); mg = set_bit(mg, a, int'(wd_f));
      tick();
    end
    we = 1'b0; a_f = 4'd5;
    for (int a = 0; a < N; a++) begin
      a_g = AW'(a); #1;
      chk("R5 comb_g read port", comb_g, bit_of(mg, a));
      chk("R5 comb_f write port", comb_f, bit_of(mf, 5));
    end

    // R6: shift registers
    load(5, 0, 0, 16'h8001, 16'h4000);
    chk("R6 cascade f after load", casc_f, 1);
    for (int k = 0; k < 2 * N + 4; k++) begin
      a_f = AW'(k % N); a_g = AW'((3 * k) % N); we = 1'b1;
      wd_f = 1'((k * 7 + 3) % 5 > 2); wd_g = 1'(k % 3 == 0);
      mf = shift_in(mf, int'(wd_f)); mg = shift_in(mg, int'(wd_g));
      tick();
      chk("R6 casc_f", casc_f, bit_of(mf, N - 1));
      chk("R6 casc_g", casc_g, bit_of(mg, N - 1));
      chk("R6 tap f", comb_f, bit_of(mf, k % N));
      chk("R6 tap g", comb_g, bit_of(mg, (3 * k) % N));
    end
    we = 1'b0; tick();
    chk("R6 no shift without we", casc_f, bit_of(mf, N - 1));

    // R7: five-input function
    load(6, 0, 0, 16'hC3A5, 16'h5A3C);
    we = 1'b1; wd_f = 1'b1; wd_g = 1'b1; tick();
    we = 1'b0;
    for (int k = 0; k < 2 * N; k++) begin
      a_f = AW'(k % N); x5 = 1'(k / N); #1;
      chk("R7 comb_f", comb_f, k < N ? bit_of(mf, k) : bit_of(mg, k - N));
    end
    x5 = 1'b0;

    // R12: configuration load wins over a same-edge write
    load(1, 0, 0, 16'h0000, 16'h0000);
    a_f = 4'd9; a_g = 4'd9; we = 1'b1; wd_f = 1'b1; wd_g = 1'b1;
    cfg_we = 1'b1; cfg_mode = 3'd1; cfg_init_f = 16'h0200; cfg_init_g = 16'h0000;
    tick();
    cfg_we = 1'b0; we = 1'b0; #1;
    chk("R12 load beats write f", comb_f, 1);
    chk("R12 load beats write g", comb_g, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule